// File: doc/BRIEF.md
# Byte-Lane Read Parity Checker

This block guards a 64-bit read data path that carries one parity bit per byte. Each of the eight byte lanes is judged on its own: the eight data bits of a lane and its parity bit must hold an even number of ones. A lane is judged only when its active-low byte select is driven low. Lanes that the bus cycle did not touch can never raise an error.

The result is registered. In the clock after a cycle with valid read data, a per-lane mismatch vector shows which selected lanes failed. A single active-low error line sums up that vector, but only when a separate active-low check enable is held low. Without valid read data, both outputs return to their idle values.

A combinational companion path computes the parity bits for outgoing write data. Each bit makes its lane even, so data written now will pass the check when it is read back.

Top module: `lane_parity_guard`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released with no valid read data, `perr_n` is 1 and `lane_err` is 8'h00.
- R2: In the clock after a cycle with `rd_valid`=1, `lane_err[n]` is 1 exactly when `be_n[n]` was 0 and the XOR of `rd_data[8n+7:8n]` and `rd_par[n]` was 1. Lane 0 is bits 7:0 and lane 7 is bits 63:56.
- R3: A lane whose `be_n[n]` was 1 during the read shows `lane_err[n]`=0, whatever its data and parity bit were.
- R4: With `chk_en_n`=0 during the read, `perr_n` is 0 in the following clock exactly when at least one bit of `lane_err` is 1. It is 1 again in the clock after that, unless a further read also fails.
- R5: With `chk_en_n`=1 during the read, `perr_n` stays 1 in the following clock. `lane_err` still reports mismatches as in R2.
- R6: In the clock after a cycle with `rd_valid`=0, `perr_n` is 1 and `lane_err` is 8'h00, whatever the other read inputs were.
- R7: `wr_par[n]` equals the XOR of `wr_data[8n+7:8n]`, so each lane together with its parity bit has even parity. The path is combinational.
- R8: A valid read with `be_n`=8'hFF gives `lane_err`=8'h00 and `perr_n`=1 in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read data and parity are valid in this cycle |
| rd_data | input | 64 | Read data, lane n on bits 8n+7:8n |
| rd_par | input | 8 | Read parity, bit n covers lane n |
| be_n | input | 8 | Active-low byte selects, bit n selects lane n |
| chk_en_n | input | 1 | Active-low enable for the summary error |
| wr_data | input | 64 | Outgoing write data |
| wr_par | output | 8 | Even parity bits for the write data |
| perr_n | output | 1 | Registered active-low parity error |
| lane_err | output | 8 | Registered per-lane mismatch vector |

## Verification
The hardest cases to reach are reads where a bad parity bit sits in a lane that is not selected, or where bad and good lanes are mixed under a sparse byte-select pattern. Random stimulus would almost never line these up. The stimulus therefore first builds correct parity for every lane. It then flips parity bits under an independent random mask and draws the byte selects from all-on, all-off and random patterns. Back-to-back failing reads, gaps in the valid strobe and toggling of the check enable exercise the one-clock error pulse and its gating.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;
    localparam int unsigned LANES  = 8;
    localparam int unsigned LANE_W = 8;

    typedef struct packed {
        logic             perr_n;
        logic [LANES-1:0] lane_err;
    } chk_state_t;
endpackage

// File: rtl/lane_parity_eval.sv
module lane_parity_eval #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    data,
    input  logic [LANES-1:0] par,
    input  logic [LANES-1:0] sel_n,
    output logic [LANES-1:0] bad
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic odd;
        assign odd    = ^{data[g*LANE_W +: LANE_W], par[g]};
        assign bad[g] = odd & ~sel_n[g];
    end
endmodule

// File: rtl/write_parity_gen.sv
module write_parity_gen #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    data,
    output logic [LANES-1:0] par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = ^data[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lane_parity_guard.sv
module lane_parity_guard
    import lane_parity_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_valid,
    input  logic [LANES*LANE_W-1:0] rd_data,
    input  logic [LANES-1:0]        rd_par,
    input  logic [LANES-1:0]        be_n,
    input  logic                    chk_en_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES-1:0]        wr_par,
    output logic                    perr_n,
    output logic [LANES-1:0]        lane_err
);
    logic [LANES-1:0] bad_lanes;
    chk_state_t       st_d, st_q;

    lane_parity_eval #(.LANES(LANES), .LANE_W(LANE_W)) u_eval (
        .data  (rd_data),
        .par   (rd_par),
        .sel_n (be_n),
        .bad   (bad_lanes)
    );

    write_parity_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_wgen (
        .data (wr_data),
        .par  (wr_par)
    );

    always_comb begin
        st_d.perr_n   = 1'b1;
        st_d.lane_err = '0;
        if (rd_valid) begin
            st_d.lane_err = bad_lanes;
            st_d.perr_n   = ~((|bad_lanes) & ~chk_en_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.perr_n   <= 1'b1;
            st_q.lane_err <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign perr_n   = st_q.perr_n;
    assign lane_err = st_q.lane_err;
endmodule

// File: rtl/lane_parity_guard_chk.sv
module lane_parity_guard_chk
    import lane_parity_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_valid,
    input logic [LANES-1:0]        be_n,
    input logic                    chk_en_n,
    input logic [LANES*LANE_W-1:0] wr_data,
    input logic [LANES-1:0]        wr_par,
    input logic                    perr_n,
    input logic [LANES-1:0]        lane_err
);
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (perr_n && lane_err == '0));

    // R3
    masked_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> ((lane_err & $past(be_n)) == '0));

    // R5
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && chk_en_n) |=> perr_n);

    // R4
    err_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> (lane_err != '0));

    // R7
    for (genvar g = 0; g < LANES; g++) begin : g_w
        wr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (^{wr_data[g*LANE_W +: LANE_W], wr_par[g]}) == 1'b0);
    end
endmodule

bind lane_parity_guard lane_parity_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .be_n     (be_n),
    .chk_en_n (chk_en_n),
    .wr_data  (wr_data),
    .wr_par   (wr_par),
    .perr_n   (perr_n),
    .lane_err (lane_err)
);

// File: tb/lane_parity_guard_test.sv
module lane_parity_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [7:0]  rd_par;
    logic [7:0]  be_n;
    logic        chk_en_n;
    logic [63:0] wr_data;
    logic [7:0]  wr_par;
    logic        perr_n;
    logic [7:0]  lane_err;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_parity_guard uut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_par(rd_par), .be_n(be_n), .chk_en_n(chk_en_n), .wr_data(wr_data),
        .wr_par(wr_par), .perr_n(perr_n), .lane_err(lane_err)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] even_bits(logic [63:0] d);
        logic [7:0] p;
        for (int l = 0; l < 8; l++)
            p[l] = ($countones(d[l*8 +: 8]) % 2) == 1;
        return p;
    endfunction

    function automatic logic [7:0] odd_lanes(logic [63:0] d, logic [7:0] p);
        logic [7:0] r;
        for (int l = 0; l < 8; l++)
            r[l] = (($countones(d[l*8 +: 8]) + int'(p[l])) % 2) == 1;
        return r;
    endfunction

    logic [7:0] exp_err;
    logic       exp_perr;
    string      tag_err, tag_perr;
    logic [7:0] prev_be;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rd_valid = 0; rd_data = '0; rd_par = '0;
        be_n = 8'hFF; chk_en_n = 0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R1 perr_n", {7'd0, perr_n}, 8'h01);
        check("R1 lane_err", lane_err, 8'h00);
        rst_n = 1;
        exp_err = 8'h00; exp_perr = 1'b1;
        tag_err = "R1"; tag_perr = "R1"; prev_be = 8'hFF;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            check({tag_err, " lane_err"}, lane_err, exp_err);
            check({tag_perr, " perr_n"}, {7'd0, perr_n}, {7'd0, exp_perr});
            if (tag_err != "R6" && tag_err != "R1")
                check("R3 masked", lane_err & prev_be, 8'h00);
            begin
                logic [63:0] d;
                logic [7:0]  flip;
                int mode;
                d = {$urandom, $urandom};
                mode = int'($urandom % 8);
                flip = (mode < 2) ? 8'h00 : 8'($urandom);
                if (mode == 7) flip = 8'h80 | 8'h01;
                rd_data = d;
                rd_par = even_bits(d) ^ flip;
                case ($urandom % 4)
                    0: be_n = 8'h00;
                    1: be_n = 8'hFF;
                    default: be_n = 8'($urandom);
                endcase
                rd_valid = ($urandom % 5) != 0;
                chk_en_n = ($urandom % 4) == 0;
                wr_data = {$urandom, $urandom};
                if (c % 97 == 5) wr_data = '1;
                #1;
                check("R7 wr_par", wr_par, even_bits(wr_data));
                if (!rd_valid) begin
                    exp_err = 8'h00; exp_perr = 1'b1;
                    tag_err = "R6"; tag_perr = "R6";
                end else begin
                    exp_err = odd_lanes(rd_data, rd_par) & ~be_n;
                    exp_perr = !(exp_err != 0 && !chk_en_n);
                    tag_err = (be_n == 8'hFF) ? "R8" : "R2";
                    tag_perr = chk_en_n ? "R5" : "R4";
                end
                prev_be = be_n;
            end
        end
        @(negedge clk);
        check({tag_err, " lane_err"}, lane_err, exp_err);
        check({tag_perr, " perr_n"}, {7'd0, perr_n}, {7'd0, exp_perr});
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule